// File: doc/BRIEF.md
# Ternary-Weight Convolution Sequencer

This block orders the work of a KxK convolution whose kernel weights are restricted to +1, 0 and -1. It never multiplies anything. It sends commands to an external image arithmetic unit, which adds or subtracts whole tiled images, and to an external image shift unit, which moves the source image by one full 4x4 tile. A +1 tap adds the currently shifted source into a positive accumulator. A -1 tap adds it into a negative accumulator. A zero tap issues no arithmetic command at all.

Between taps, the source image walks the kernel window in serpentine order. It moves east along even kernel rows, west along odd kernel rows, and south once at the end of every row. When the whole window has been covered, a single subtraction forms the result as positive minus negative, and the block raises a one-cycle completion pulse. Weight codes are read from a small synchronous memory, one tap at a time, with one cycle of read latency.

Top module: `tconv_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done`, `ar_req` and `sh_req` are all low.
- R2: After `start` is accepted, the first two arithmetic commands are clear-positive (`ar_op`=0) and then clear-negative (`ar_op`=1). Both complete before any other command is issued.
- R3: The tap in kernel row r, column c reads weight address r*K+c. Code 2'b01 issues add-to-positive (`ar_op`=2). Code 2'b11 issues add-to-negative (`ar_op`=3). Codes 2'b00 and 2'b10 issue no arithmetic command for that tap.
- R4: After every tap, exactly one horizontal shift is issued: east (`sh_dir`=0) in even kernel rows, counting the first row as row 0, and west (`sh_dir`=1) in odd rows.
- R5: After the K horizontal shifts of a kernel row, exactly one south shift (`sh_dir`=2) is issued, including after the last row.
- R6: Every shift command presents a distance of 4 cells on `sh_dist`.
- R7: After the final south shift, exactly one subtraction (`ar_op`=4) is issued. The cycle after it completes, `done` is high for exactly one cycle, and both request lines are low while `done` is high.
- R8: A command counts as completed in a cycle where its request and its done input are both high. Until then, the request stays high and its op or direction stays unchanged. The two requests are never high together.
- R9: A `start` pulse that arrives while a convolution is in progress has no effect: the command stream and the single `done` pulse are the same as without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a convolution when idle |
| done | output | 1 | One-cycle pulse when the result is formed |
| w_addr | output | 5 | Weight memory address (r*K+c) |
| w_rdata | input | 2 | Weight code, valid one cycle after the address |
| ar_req | output | 1 | Arithmetic command request |
| ar_op | output | 3 | Arithmetic op: 0 clr P, 1 clr N, 2 P+=src, 3 N+=src, 4 out=P-N |
| ar_done | input | 1 | Arithmetic command completed |
| sh_req | output | 1 | Shift command request |
| sh_dir | output | 2 | Shift direction: 0 east, 1 west, 2 south |
| sh_dist | output | 3 | Shift distance in cells |
| sh_done | input | 1 | Shift command completed |

## Verification
The hardest situation to reach is a restart request that lands in the middle of a scan while both external units are stalling. A second `start` at that moment would corrupt the serpentine position without being visible at any single port. The bench pulses `start` several times during a run whose responders answer only after several cycles of latency. It then compares the full logged stream of completed commands against a sequence computed from the weights, and counts the `done` pulses. The weight patterns include the unused code 2'b10, all-zero kernels (shift-only scans) and alternating signs, so that both routing paths and the skip path are seen in every row parity.

// File: rtl/tconv_pkg.sv
// Shared encodings for the ternary convolution sequencer.
// Assumes the arithmetic and shift units decode these exact values.
package tconv_pkg;
    typedef enum logic [2:0] {
        AOP_CLR_POS = 3'd0,
        AOP_CLR_NEG = 3'd1,
        AOP_ADD_POS = 3'd2,
        AOP_ADD_NEG = 3'd3,
        AOP_SUB     = 3'd4
    } arith_op_e;

    typedef enum logic [1:0] {
        SDIR_EAST  = 2'd0,
        SDIR_WEST  = 2'd1,
        SDIR_SOUTH = 2'd2
    } shift_dir_e;

    typedef enum logic [1:0] {
        TAP_SKIP = 2'd0,
        TAP_POS  = 2'd1,
        TAP_NEG  = 2'd2
    } tap_kind_e;

    localparam logic [1:0] WCODE_POS = 2'b01;
    localparam logic [1:0] WCODE_NEG = 2'b11;
endpackage

// File: rtl/tconv_wdecode.sv
// Maps a 2-bit ternary weight code to the routing decision for one tap.
// Assumes 01 means +1 and 11 means -1; 00 and the unused 10 both skip.
module tconv_wdecode
    import tconv_pkg::*;
(
    input  logic [1:0] code,
    output tap_kind_e  kind
);
    // Purely combinational classification of the code.
    always_comb begin
        case (code)
            WCODE_POS: kind = TAP_POS;
            WCODE_NEG: kind = TAP_NEG;
            default:   kind = TAP_SKIP;
        endcase
    end
endmodule

// File: rtl/tconv_walker.sv
// Tracks the kernel row and column of the serpentine scan and the matching
// weight address. Assumes adv_col and adv_row are never raised together and
// that the controller only advances within the KxK window.
module tconv_walker #(
    parameter int K      = 5,
    parameter int IDX_W  = 3,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              adv_col,
    input  logic              adv_row,
    output logic [ADDR_W-1:0] addr,
    output logic              last_col,
    output logic              last_row,
    output logic              odd_row
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(K - 1);

    logic [IDX_W-1:0] row_q;
    logic [IDX_W-1:0] col_q;

    // Row, column and linear address counters; the address steps by one on
    // every advance because rows are stored back to back.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            row_q <= '0;
            col_q <= '0;
            addr  <= '0;
        end else if (adv_col) begin
            col_q <= col_q + 1'b1;
            addr  <= addr + 1'b1;
        end else if (adv_row) begin
            row_q <= row_q + 1'b1;
            col_q <= '0;
            addr  <= addr + 1'b1;
        end
    end

    // Position flags used by the controller.
    always_comb begin
        last_col = (col_q == LAST_IDX);
        last_row = (row_q == LAST_IDX);
        odd_row  = row_q[0];
    end
endmodule

// File: rtl/tconv_seq.sv
// Ternary-weight convolution sequencer. Clears both accumulators, walks the
// source image over the KxK window in serpentine order, routes each tap into
// the positive or negative accumulator or skips it, then issues P-N once.
// Assumes: synchronous weight memory with one cycle read latency; each unit
// answers a held request with a done pulse; a request that stays high after
// a done is a new command.
module tconv_seq
    import tconv_pkg::*;
#(
    parameter int K          = 5,
    parameter int SHIFT_STEP = 4,
    parameter int TAPS       = K * K,
    parameter int ADDR_W     = (TAPS > 1) ? $clog2(TAPS) : 1,
    parameter int STEP_W     = $clog2(SHIFT_STEP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic [ADDR_W-1:0] w_addr,
    input  logic [1:0]        w_rdata,
    output logic              ar_req,
    output logic [2:0]        ar_op,
    input  logic              ar_done,
    output logic              sh_req,
    output logic [1:0]        sh_dir,
    output logic [STEP_W-1:0] sh_dist,
    input  logic              sh_done
);
    localparam int IDX_W = (K > 1) ? $clog2(K) : 1;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CLR_P, ST_CLR_N, ST_FETCH, ST_DECODE,
        ST_ADD, ST_HSHIFT, ST_VSHIFT, ST_SUB, ST_DONE
    } state_e;

    state_e    state_q, state_d;
    logic      add_neg_q;
    tap_kind_e kind;
    logic      restart, adv_col, adv_row;
    logic      last_col, last_row, odd_row;

    tconv_wdecode u_dec (
        .code (w_rdata),
        .kind (kind)
    );

    tconv_walker #(
        .K      (K),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .adv_col  (adv_col),
        .adv_row  (adv_row),
        .addr     (w_addr),
        .last_col (last_col),
        .last_row (last_row),
        .odd_row  (odd_row)
    );

    // Next-state and walker control for the scan.
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        adv_col = 1'b0;
        adv_row = 1'b0;
        case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_CLR_P;
                restart = 1'b1;
            end
            ST_CLR_P:  if (ar_done) state_d = ST_CLR_N;
            ST_CLR_N:  if (ar_done) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = (kind == TAP_SKIP) ? ST_HSHIFT : ST_ADD;
            ST_ADD:    if (ar_done) state_d = ST_HSHIFT;
            ST_HSHIFT: if (sh_done) begin
                if (last_col) begin
                    state_d = ST_VSHIFT;
                end else begin
                    state_d = ST_FETCH;
                    adv_col = 1'b1;
                end
            end
            ST_VSHIFT: if (sh_done) begin
                if (last_row) begin
                    state_d = ST_SUB;
                end else begin
                    state_d = ST_FETCH;
                    adv_row = 1'b1;
                end
            end
            ST_SUB:  if (ar_done) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and the captured routing of the current tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            add_neg_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DECODE) add_neg_q <= (kind == TAP_NEG);
        end
    end

    // Command outputs decoded from the registered state.
    always_comb begin
        ar_req  = (state_q == ST_CLR_P) || (state_q == ST_CLR_N) ||
                  (state_q == ST_ADD)   || (state_q == ST_SUB);
        sh_req  = (state_q == ST_HSHIFT) || (state_q == ST_VSHIFT);
        done    = (state_q == ST_DONE);
        sh_dist = STEP_W'(SHIFT_STEP);
        case (state_q)
            ST_CLR_N: ar_op = AOP_CLR_NEG;
            ST_ADD:   ar_op = add_neg_q ? AOP_ADD_NEG : AOP_ADD_POS;
            ST_SUB:   ar_op = AOP_SUB;
            default:  ar_op = AOP_CLR_POS;
        endcase
        if (state_q == ST_VSHIFT) sh_dir = SDIR_SOUTH;
        else if (odd_row)         sh_dir = SDIR_WEST;
        else                      sh_dir = SDIR_EAST;
    end
endmodule

// File: rtl/tconv_seq_chk.sv
// Protocol checker for tconv_seq, attached by bind. Observes ports only.
module tconv_seq_chk #(
    parameter int K      = 5,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [ADDR_W-1:0] w_addr,
    input logic              ar_req,
    input logic [2:0]        ar_op,
    input logic              ar_done,
    input logic              sh_req,
    input logic [1:0]        sh_dir,
    input logic              sh_done
);
    localparam int TAPS = K * K;

    // R8: never two units busy at once.
    a_r8_single_unit: assert property (@(posedge clk) disable iff (!rst_n)
        !(ar_req && sh_req));

    // R8: arithmetic command held until acknowledged.
    a_r8_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_req && !ar_done) |=> (ar_req && $stable(ar_op)));

    // R8: shift command held until acknowledged.
    a_r8_sh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_req && !sh_done) |=> (sh_req && $stable(sh_dir)));

    // R7: completion is a single-cycle pulse with no command pending.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ar_req && !sh_req));

    // R7: the finishing subtraction is followed directly by done.
    a_r7_sub_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_req && ar_done && ar_op == 3'd4) |=> done);

    // R3: weight address stays inside the kernel.
    a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(w_addr) < TAPS));
endmodule

bind tconv_seq tconv_seq_chk #(.K(K), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (done),
    .w_addr  (w_addr),
    .ar_req  (ar_req),
    .ar_op   (ar_op),
    .ar_done (ar_done),
    .sh_req  (sh_req),
    .sh_dir  (sh_dir),
    .sh_done (sh_done)
);

// File: tb/tconv_seq_test.sv
// Directed bench: responders model the arithmetic and shift units, every
// completed command is logged and compared with a stream built from weights.
module tconv_seq_test;
    localparam int K    = 5;
    localparam int TAPS = K * K;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       done;
    logic [4:0] w_addr;
    logic [1:0] w_rdata = 2'b00;
    logic       ar_req, sh_req;
    logic [2:0] ar_op;
    logic [1:0] sh_dir;
    logic [2:0] sh_dist;
    logic       ar_done = 1'b0, sh_done = 1'b0;

    always #4 clk = ~clk;

    tconv_seq #(.K(K)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .w_addr(w_addr), .w_rdata(w_rdata),
        .ar_req(ar_req), .ar_op(ar_op), .ar_done(ar_done),
        .sh_req(sh_req), .sh_dir(sh_dir), .sh_dist(sh_dist), .sh_done(sh_done)
    );

    logic [1:0] wmem [TAPS];
    int lat_ar = 0, lat_sh = 0, ar_cnt = 0, sh_cnt = 0;
    int log_q[$];
    int exp_q[$];
    int done_cnt = 0, both_cnt = 0, dist_bad = 0;
    int n_chk = 0, n_fail = 0;

    // Synchronous weight memory, one cycle of latency.
    always @(posedge clk) w_rdata <= (32'(w_addr) < TAPS) ? wmem[w_addr] : 2'b00;

    // Arithmetic unit model.
    always @(posedge clk) begin
        if (!rst_n) begin ar_done <= 1'b0; ar_cnt <= 0; end
        else if (ar_done) begin ar_done <= 1'b0; ar_cnt <= 0; end
        else if (ar_req) begin
            if (ar_cnt >= lat_ar) ar_done <= 1'b1; else ar_cnt <= ar_cnt + 1;
        end
    end

    // Shift unit model.
    always @(posedge clk) begin
        if (!rst_n) begin sh_done <= 1'b0; sh_cnt <= 0; end
        else if (sh_done) begin sh_done <= 1'b0; sh_cnt <= 0; end
        else if (sh_req) begin
            if (sh_cnt >= lat_sh) sh_done <= 1'b1; else sh_cnt <= sh_cnt + 1;
        end
    end

    // Command log: arith ops as 0..4, shifts as 8+direction.
    always @(posedge clk) begin
        if (rst_n) begin
            if (ar_req && ar_done) log_q.push_back(int'(ar_op));
            if (sh_req && sh_done) begin
                log_q.push_back(8 + int'(sh_dir));
                if (sh_dist != 3'd4) dist_bad++;
            end
            if (done) done_cnt++;
            if (ar_req && sh_req) both_cnt++;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Builds the expected command stream from the weight memory.
    task automatic build_expected();
        exp_q.delete();
        exp_q.push_back(0);
        exp_q.push_back(1);
        for (int r = 0; r < K; r++) begin
            for (int c = 0; c < K; c++) begin
                if (wmem[r*K+c] == 2'b01) exp_q.push_back(2);
                else if (wmem[r*K+c] == 2'b11) exp_q.push_back(3);
                exp_q.push_back(8 + (r % 2));
            end
            exp_q.push_back(10);
        end
        exp_q.push_back(4);
    endtask

    // Fills the weights with one of several patterns.
    task automatic fill(int pat);
        for (int i = 0; i < TAPS; i++) begin
            case (pat)
                0: wmem[i] = 2'b00;
                1: wmem[i] = 2'b01;
                2: wmem[i] = 2'b11;
                3: wmem[i] = 2'((i * 7 + 3) % 4);
                default: wmem[i] = (i % 3 == 0) ? 2'b10 : ((i % 2 == 0) ? 2'b01 : 2'b11);
            endcase
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "done in reset", int'(done), 0);
        chk("R1", "ar_req in reset", int'(ar_req), 0);
        chk("R1", "sh_req in reset", int'(sh_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "requests idle after reset", int'(ar_req | sh_req | done), 0);
    endtask

    // Runs one convolution and checks the whole command stream.
    task automatic t_run(string name, int pat, int lar, int lsh, bit poke);
        int n_pos, n_neg, n_east, n_west, n_south, mism;
        fill(pat);
        build_expected();
        lat_ar = lar;
        lat_sh = lsh;
        log_q.delete();
        done_cnt = 0; both_cnt = 0; dist_bad = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < 20000 && done_cnt == 0; i++) begin
            @(negedge clk);
            start = poke && (i == 30 || i == 90 || i == 150);
        end
        start = 1'b0;
        chk("R7", {name, " idle when done"}, int'(ar_req | sh_req), 0);
        repeat (40) @(negedge clk);
        n_pos = 0; n_neg = 0; n_east = 0; n_west = 0; n_south = 0; mism = 0;
        foreach (log_q[i]) begin
            case (log_q[i])
                2: n_pos++;
                3: n_neg++;
                8: n_east++;
                9: n_west++;
                10: n_south++;
                default: ;
            endcase
        end
        for (int i = 0; i < exp_q.size(); i++)
            if (i >= log_q.size() || log_q[i] != exp_q[i]) mism++;
        chk("R2", {name, " first clear"}, log_q.size() > 0 ? log_q[0] : -1, 0);
        chk("R2", {name, " second clear"}, log_q.size() > 1 ? log_q[1] : -1, 1);
        chk("R3", {name, " stream length"}, log_q.size(), exp_q.size());
        chk("R3", {name, " stream mismatches"}, mism, 0);
        begin
            int e_pos = 0, e_neg = 0;
            for (int i = 0; i < TAPS; i++) begin
                if (wmem[i] == 2'b01) e_pos++;
                if (wmem[i] == 2'b11) e_neg++;
            end
            chk("R3", {name, " positive adds"}, n_pos, e_pos);
            chk("R3", {name, " negative adds"}, n_neg, e_neg);
        end
        chk("R4", {name, " east shifts"}, n_east, K * ((K + 1) / 2));
        chk("R4", {name, " west shifts"}, n_west, K * (K / 2));
        chk("R5", {name, " south shifts"}, n_south, K);
        chk("R6", {name, " bad distances"}, dist_bad, 0);
        chk("R7", {name, " last command"}, log_q.size() > 0 ? log_q[log_q.size()-1] : -1, 4);
        chk(poke ? "R9" : "R7", {name, " done pulses"}, done_cnt, 1);
        chk("R8", {name, " overlapping requests"}, both_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_run("zeros", 0, 0, 0, 1'b0);
        t_run("plus", 1, 1, 0, 1'b0);
        t_run("minus", 2, 0, 2, 1'b0);
        t_run("mixed", 3, 2, 1, 1'b0);
        t_run("alternating", 4, 0, 0, 1'b0);
        t_run("restart_busy", 3, 4, 3, 1'b1);
        summary();
        $finish;
    end
endmodule